// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block keeps stores that are still speculative in a small queue, so that memory is not written until the store is confirmed. Each entry holds a byte address, an access width of 1, 2 or 4 bytes, and 32 bits of data. A store enters through a valid/ready handshake. A commit pulse retires the oldest entry to a memory write port, and the entries leave in program order. A flush pulse discards every uncommitted entry in a single cycle.

Every load of 1, 2 or 4 bytes, at any byte alignment, is compared against all valid entries. There are three outcomes:

- No entry overlaps the load, so the load reads memory.
- Exactly one entry overlaps it with the same start address and the same width, so the buffered value is forwarded.
- Any other overlap, including a partial one or several overlapping entries, raises a stall.

The block never assembles a value from pieces of several stores. The load result is registered and appears one cycle after the request.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset the buffer is empty, `st_ready` is 1, and `res_valid` and `mem_wr_en` are 0.
- R2: A store is taken into the buffer in a cycle where `st_valid` and `st_ready` are both 1. `st_ready` is 0 while DEPTH entries are held or while `flush` is 1. A store offered while `st_ready` is 0 is never recorded.
- R3: When `commit` is 1, `flush` is 0 and the buffer is not empty, the oldest entry is presented in the same cycle on `mem_wr_addr`, `mem_wr_size` and `mem_wr_data` with `mem_wr_en` 1, and it is then removed. Entries leave in the order in which they were accepted. When the buffer is empty, `mem_wr_en` stays 0.
- R4: A cycle with `flush` at 1 empties the buffer. Later loads see none of the flushed entries, and a later commit writes nothing.
- R5: The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Code 3 is treated as 4 bytes. An access covers the bytes from its address up to address+width−1.
- R6: `res_valid` is 1 exactly in the cycle after a cycle with `ld_valid` at 1. The result code on `res_kind` is 0 for a memory read, 1 for a forward and 2 for a stall.
- R7: When no valid entry overlaps the load's bytes, the result is a memory read and `res_data` is 0.
- R8: When exactly one valid entry overlaps the load, and it has the same address and the same width, the result is a forward. `res_data` holds that entry's low bytes (little-endian), zero-extended to 32 bits.
- R9: When exactly one valid entry overlaps the load but differs in address or in width (a partial overlap), the result is a stall and `res_data` is 0.
- R10: When two or more valid entries overlap the load, the result is a stall, even if one of them matches exactly.
- R11: Byte addresses wrap modulo 2^AW, so an access that runs past the top address continues at address 0.
- R12: An entry that has been committed no longer takes part in the load check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 32 | Store data, little-endian |
| ld_valid | input | 1 | Load request valid |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| res_valid | output | 1 | Load result valid (one cycle after the request) |
| res_kind | output | 2 | 0 memory, 1 forward, 2 stall |
| res_data | output | 32 | Forwarded value, zero-extended |
| commit | input | 1 | Retire the oldest entry |
| flush | input | 1 | Discard all entries |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_size | output | 2 | Memory write size code |
| mem_wr_data | output | 32 | Memory write data |

## Verification
Every cycle, the assertions check the following properties:

- The occupancy never exceeds the depth, and `st_ready` drops when the buffer is full.
- A flush leaves the buffer empty.
- No memory write is issued from an empty buffer.
- The load result follows the request by exactly one cycle.
- A forward is chosen only when exactly one entry overlaps the load.

Only the bench scenarios can show the rest:

- That the overlap ranges are right for each width and alignment, including wraparound at the top address.
- That forwarded data is zero-extended correctly.
- That entries commit in program order.
- That committed or flushed entries stop affecting loads.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        RK_MEM   = 2'd0,
        RK_FWD   = 2'd1,
        RK_STALL = 2'd2
    } res_kind_e;

    // Bytes covered by a size code; code 3 behaves as a word.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] code);
        case (code)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/sbuf_overlap.sv
// Compares one buffered store against the current load.
module sbuf_overlap #(
    parameter int AW = 16
) (
    input  logic          ent_vld,
    input  logic [AW-1:0] ent_addr,
    input  logic [1:0]    ent_size,
    input  logic [AW-1:0] ld_addr,
    input  logic [1:0]    ld_size,
    output logic          hit,
    output logic          exact
);
    import sbuf_pkg::*;

    logic [AW-1:0] dist_ld_from_st;
    logic [AW-1:0] dist_st_from_ld;
    logic [AW-1:0] st_len;
    logic [AW-1:0] ld_len;

    always_comb begin
        // Modular distances make the ranges wrap around the address space.
        dist_ld_from_st = ld_addr - ent_addr;
        dist_st_from_ld = ent_addr - ld_addr;
        st_len = AW'(size_bytes(ent_size));
        ld_len = AW'(size_bytes(ld_size));
        hit    = ent_vld && ((dist_ld_from_st < st_len) || (dist_st_from_ld < ld_len));
        exact  = ent_vld && (ent_addr == ld_addr) &&
                 (size_bytes(ent_size) == size_bytes(ld_size));
    end
endmodule

// File: rtl/sbuf_select.sv
// Turns per-entry hit/exact flags into one load outcome.
module sbuf_select #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0]       hit_vec,
    input  logic [DEPTH-1:0]       exact_vec,
    input  logic [DEPTH-1:0][31:0] ent_data,
    input  logic [1:0]             ld_size,
    output logic [1:0]             kind,
    output logic [31:0]            fwd_data
);
    import sbuf_pkg::*;

    localparam int CNTW = $clog2(DEPTH + 1);

    logic [CNTW-1:0] n_hits;
    logic [DEPTH-1:0] pick;
    logic [31:0] acc;

    always_comb begin
        n_hits = '0;
        for (int i = 0; i < DEPTH; i++) begin
            n_hits = n_hits + CNTW'(hit_vec[i]);
        end
        pick = hit_vec & exact_vec;
        acc  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pick[i]) acc = acc | ent_data[i];
        end
        kind     = RK_STALL;
        fwd_data = '0;
        if (n_hits == '0) begin
            kind = RK_MEM;
        end else if (n_hits == CNTW'(1) && |pick) begin
            kind     = RK_FWD;
            fwd_data = acc & size_mask(ld_size);
        end
    end
endmodule

// File: rtl/store_fwd_buf.sv
module store_fwd_buf #(
    parameter int AW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [1:0]    st_size,
    input  logic [31:0]   st_data,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [1:0]    ld_size,
    output logic          res_valid,
    output logic [1:0]    res_kind,
    output logic [31:0]   res_data,
    input  logic          commit,
    input  logic          flush,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [1:0]    mem_wr_size,
    output logic [31:0]   mem_wr_data
);
    import sbuf_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [DEPTH-1:0]          vld;
        logic [DEPTH-1:0][AW-1:0]  addr;
        logic [DEPTH-1:0][1:0]     size;
        logic [DEPTH-1:0][31:0]    data;
        logic [PW-1:0]             head;
        logic [PW-1:0]             tail;
        logic [CW-1:0]             count;
        logic                      res_valid;
        logic [1:0]                res_kind;
        logic [31:0]               res_data;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] exact_vec;
    logic [1:0]       sel_kind;
    logic [31:0]      sel_data;
    logic             push;
    logic             pop;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            sbuf_overlap #(.AW(AW)) i_cmp (
                .ent_vld  (s_q.vld[g]),
                .ent_addr (s_q.addr[g]),
                .ent_size (s_q.size[g]),
                .ld_addr  (ld_addr),
                .ld_size  (ld_size),
                .hit      (hit_vec[g]),
                .exact    (exact_vec[g])
            );
        end
    endgenerate

    sbuf_select #(.DEPTH(DEPTH)) i_sel (
        .hit_vec   (hit_vec),
        .exact_vec (exact_vec),
        .ent_data  (s_q.data),
        .ld_size   (ld_size),
        .kind      (sel_kind),
        .fwd_data  (sel_data)
    );

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        ptr_inc = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_ready = (s_q.count != CW'(DEPTH)) && !flush;
        push     = st_valid && st_ready;
        pop      = commit && !flush && (s_q.count != '0);

        mem_wr_en   = pop;
        mem_wr_addr = s_q.addr[s_q.head];
        mem_wr_size = s_q.size[s_q.head];
        mem_wr_data = s_q.data[s_q.head];

        s_d = s_q;
        if (flush) begin
            s_d.vld   = '0;
            s_d.head  = '0;
            s_d.tail  = '0;
            s_d.count = '0;
        end else begin
            if (pop) begin
                s_d.vld[s_q.head] = 1'b0;
                s_d.head          = ptr_inc(s_q.head);
            end
            if (push) begin
                s_d.vld[s_q.tail]  = 1'b1;
                s_d.addr[s_q.tail] = st_addr;
                s_d.size[s_q.tail] = st_size;
                s_d.data[s_q.tail] = st_data;
                s_d.tail           = ptr_inc(s_q.tail);
            end
            if (push && !pop)      s_d.count = s_q.count + CW'(1);
            else if (pop && !push) s_d.count = s_q.count - CW'(1);
        end

        s_d.res_valid = ld_valid;
        s_d.res_kind  = ld_valid ? sel_kind : RK_MEM;
        s_d.res_data  = ld_valid ? sel_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
        end else begin
            s_q       <= s_d;
        end
    end

    assign res_valid = s_q.res_valid;
    assign res_kind  = s_q.res_kind;
    assign res_data  = s_q.res_data;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));

    // R2
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == CW'(DEPTH)) |-> !st_ready);

    // R3
    empty_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == '0) |-> !mem_wr_en);

    // R4
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.count == '0) && (s_q.vld == '0));

    // R6
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> res_valid);

    // R6
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !res_valid);

    // R8 R10
    single_hit_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && sel_kind == RK_FWD) |-> ($countones(hit_vec) == 1));

endmodule

// File: tb/test_store_fwd_buf.sv
module test_store_fwd_buf;

    localparam int AW = 16;
    localparam int DEPTH = 8;
    localparam int NV = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [1:0]    st_size = '0;
    logic [31:0]   st_data = '0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [1:0]    ld_size = '0;
    logic          res_valid;
    logic [1:0]    res_kind;
    logic [31:0]   res_data;
    logic          commit = 1'b0;
    logic          flush = 1'b0;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [1:0]    mem_wr_size;
    logic [31:0]   mem_wr_data;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    store_fwd_buf #(.AW(AW), .DEPTH(DEPTH)) i_store_fwd_buf (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_size(st_size), .st_data(st_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .res_valid(res_valid), .res_kind(res_kind), .res_data(res_data),
        .commit(commit), .flush(flush),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_size(mem_wr_size), .mem_wr_data(mem_wr_data)
    );

    // Kind codes: 0 memory, 1 forward, 2 stall.
    // Buffer during the table: 0x0100/4B, 0x0203/2B, 0x0300/1B,
    // 0x0500/2B twice, 0xFFFE/4B (wraps to 0x0001).
    localparam logic [15:0] V_ADDR [NV] = '{
        16'h0100, 16'h0100, 16'h0100, 16'h0103, 16'h00FD, 16'h00FC, 16'h0203,
        16'h0204, 16'h0205, 16'h0300, 16'h0500, 16'h0600, 16'h0001, 16'h0002};
    localparam logic [1:0] V_SIZE [NV] = '{
        2'd2, 2'd3, 2'd1, 2'd0, 2'd2, 2'd2, 2'd1,
        2'd2, 2'd0, 2'd0, 2'd1, 2'd2, 2'd0, 2'd0};
    localparam logic [1:0] V_KIND [NV] = '{
        2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd0, 2'd1,
        2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd0};
    localparam logic [31:0] V_DATA [NV] = '{
        32'hDDCCBBAA, 32'hDDCCBBAA, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00001234,
        32'h0, 32'h0, 32'h0000005A, 32'h0, 32'h0, 32'h0, 32'h0};
    // Row tags: 0 R8, 1 R5 (code 3), 2-4 R9, 5 R7, 6 R8 zero-extend,
    // 7 R9 misaligned, 8 R7, 9 R8, 10 R10, 11 R7, 12 R11 wrap stall, 13 R11 wrap clear.

    localparam logic [15:0] C_ADDR [DEPTH] = '{
        16'h0100, 16'h0203, 16'h0300, 16'h0500, 16'h0500, 16'hFFFE, 16'h0700, 16'h0708};
    localparam logic [31:0] C_DATA [DEPTH] = '{
        32'hDDCCBBAA, 32'hABCD1234, 32'hFFFFFF5A, 32'h00001111,
        32'h00002222, 32'h77777777, 32'h000000A1, 32'h000000A2};
    localparam logic [1:0] C_SIZE [DEPTH] = '{
        2'd2, 2'd1, 2'd0, 2'd1, 2'd1, 2'd2, 2'd0, 2'd0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic [15:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_size = s; st_data = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] a, input logic [1:0] s);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_size = s;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 st_ready", 32'(st_ready), 32'd1);
        chk("R1 res_valid", 32'(res_valid), 32'd0);
        chk("R1 mem_wr_en", 32'(mem_wr_en), 32'd0);

        for (int i = 0; i < 6; i++) do_store(C_ADDR[i], C_SIZE[i], C_DATA[i]);

        for (int i = 0; i < NV; i++) begin
            do_load(V_ADDR[i], V_SIZE[i]);
            chk($sformatf("R6 res_valid row %0d", i), 32'(res_valid), 32'd1);
            chk($sformatf("R7/R8/R9 kind row %0d", i), 32'(res_kind), 32'(V_KIND[i]));
            chk($sformatf("R8 data row %0d", i), res_data, V_DATA[i]);
        end
        @(negedge clk);
        // R6: no load in the previous cycle
        chk("R6 idle", 32'(res_valid), 32'd0);

        do_store(C_ADDR[6], C_SIZE[6], C_DATA[6]);
        do_store(C_ADDR[7], C_SIZE[7], C_DATA[7]);
        // R2: full
        chk("R2 full ready", 32'(st_ready), 32'd0);
        do_store(16'h0800, 2'd2, 32'hDEADBEEF);

        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            commit = 1'b1;
            #1;
            chk($sformatf("R3 wr_en %0d", i), 32'(mem_wr_en), 32'd1);
            chk($sformatf("R3 wr_addr %0d", i), 32'(mem_wr_addr), 32'(C_ADDR[i]));
            chk($sformatf("R3 wr_size %0d", i), 32'(mem_wr_size), 32'(C_SIZE[i]));
            chk($sformatf("R3 wr_data %0d", i), mem_wr_data, C_DATA[i]);
            @(negedge clk);
            commit = 1'b0;
            if (i == 0) begin
                // R12: committed 0x0100 no longer forwards
                do_load(16'h0100, 2'd2);
                chk("R12 kind", 32'(res_kind), 32'd0);
            end
        end
        // R2/R3: the rejected store never appears; empty gives no write
        @(negedge clk);
        commit = 1'b1;
        #1;
        chk("R2 R3 empty commit", 32'(mem_wr_en), 32'd0);
        @(negedge clk);
        commit = 1'b0;

        do_store(16'h0900, 2'd2, 32'h12345678);
        do_load(16'h0900, 2'd2);
        chk("R8 pre-flush kind", 32'(res_kind), 32'd1);
        chk("R8 pre-flush data", res_data, 32'h12345678);
        @(negedge clk);
        flush = 1'b1;
        #1;
        // R2: not ready during flush
        chk("R2 flush ready", 32'(st_ready), 32'd0);
        @(negedge clk);
        flush = 1'b0;
        do_load(16'h0900, 2'd2);
        // R4
        chk("R4 flushed load", 32'(res_kind), 32'd0);
        @(negedge clk);
        commit = 1'b1;
        #1;
        chk("R4 flushed commit", 32'(mem_wr_en), 32'd0);
        @(negedge clk);
        commit = 1'b0;
        chk("R1 R2 ready after flush", 32'(st_ready), 32'd1);

        finish_run();
    end

endmodule